// File: doc/BRIEF.md
# Multi-Pointer Ternary Element Rotation Selector

This block sits between a digital delta-sigma modulator and a segmented DAC built from eight unit cells. For every sample strobe it takes a small signed code and decides which cells conduct and in which polarity. In ternary mode each cell can push +1, -1 or nothing, so the array produces seventeen levels from -8 to +8. In binary mode a cell is either on or off, and the array produces nine levels from 0 to 8.

Cell mismatch is spread by data-weighted averaging. The block selects a run of adjacent cells that starts at a rotation pointer and then moves the pointer past the run. Two movement schemes are available. The wrapping scheme always moves forward and wraps modulo eight. The bouncing scheme moves back and forth across the array and turns around at its ends. One, two or four independent pointers can be kept, and they are used in turn, one per sample. With two or four pointers the mismatch error is shaped away from the band of a highpass or bandpass modulator instead of a lowpass one.

Any change of configuration returns every pointer to cell 0, turns every bounce direction upward and restarts the pointer rotation. The cell drives are registered and appear one clock after the strobe.

Top module: `dwa_sel`

## Requirements
- R1: While rstN is low, outValid, cellPos and cellNeg are all zero on the next clock.
- R2: outValid is high exactly in the cycle after a clock with codeValid high. The cellPos and cellNeg outputs keep their value in cycles that follow a clock without codeValid.
- R3: In ternary mode (modeTernary=1), popcount(cellPos) minus popcount(cellNeg) equals the clamped code, and no cell has cellPos and cellNeg both set. A cell with cellPos[i]=1 drives +1, a cell with cellNeg[i]=1 drives -1, and a cell with neither bit set drives 0.
- R4: In binary mode (modeTernary=0), cellNeg is zero and popcount(cellPos) equals the clamped code.
- R5: codeIn is a 5-bit two's-complement value. Ternary mode clamps it to [-8,+8]. Binary mode clamps it to [0,8], so a negative code gives no cell.
- R6: With wrapping rotation (typeBounce=0), a code of magnitude k selects k cells in a row, starting at the active pointer and going upward modulo 8. The pointer then moves to (pointer+k) mod 8.
- R7: With bouncing rotation (typeBounce=1), the pointer is a boundary b in 0..8 with a direction, starting at b=0 going up. Going up, if b+k<=8 the cells b..b+k-1 are used and b becomes b+k. Otherwise, if b>=k, the direction turns down. Going down, if b>=k the cells b-k..b-1 are used and b becomes b-k. Otherwise, if b+k<=8, the direction turns up. If neither fits, a block at the far end is used: cells 8-k..7 with b=8-k going down, when the run was going up, or cells 0..k-1 with b=k going up, when the run was going down.
- R8: ptrCountSel selects 1 pointer (0), 2 pointers (1) or 4 pointers (2 or 3). Successive strobes use pointer 0, 1, …, N-1 and then pointer 0 again, and each pointer keeps its own position and direction.
- R9: A change of any configuration input (modeTernary, typeBounce, ptrCountSel) resets all pointers to 0 and all directions to up, and the next strobe uses pointer 0.
- R10: With wrapping rotation and a constant magnitude k, every cell is used exactly k times over 8 consecutive strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| modeTernary | input | 1 | 1: signed ternary cells, 0: binary cells |
| typeBounce | input | 1 | 0: wrapping rotation, 1: back-and-forth rotation |
| ptrCountSel | input | 2 | Number of pointers: 0→1, 1→2, 2/3→4 |
| codeValid | input | 1 | Sample strobe |
| codeIn | input | 5 | Two's-complement modulator code |
| cellPos | output | 8 | Cell i drives +1 |
| cellNeg | output | 8 | Cell i drives -1 |
| outValid | output | 1 | Drives updated by the previous strobe |

## Verification
The hardest case to reach from the ports is the bouncing fallback, where the current boundary fits the run in neither direction. The pointer has to sit near the middle of the array, and a large magnitude has to arrive while it is there. The stimulus reaches this by walking one pointer with codes of 3, 5, 5, 6 and 4, which leaves the boundary at 2 going down. A code of 7 then fits neither way and must select cells 0..6. Wrapping runs that cross cell 7 and per-pointer independence are set up the same way, by choosing code sequences that are worked out in advance.

// File: rtl/dwa_pkg.sv
package dwa_pkg;
  localparam int unsigned CELL_COUNT = 8;
  localparam int unsigned MAX_PTRS   = 4;
  localparam int unsigned MAG_W      = $clog2(CELL_COUNT + 1);
  localparam int unsigned SLOT_W     = $clog2(MAX_PTRS);
  localparam int unsigned IDX_W      = $clog2(CELL_COUNT);

  typedef struct packed {
    logic              clear;   // configuration changed: zero all pointers
    logic              load;    // a sample is being taken this cycle
    logic              bounce;  // back-and-forth rotation selected
    logic              neg;     // clamped code is negative
    logic [SLOT_W-1:0] slot;    // pointer used by this sample
    logic [MAG_W-1:0]  mag;     // clamped magnitude
  } ctrlStrobeT;
endpackage

// File: rtl/dwa_ctrl.sv
module dwa_ctrl
  import dwa_pkg::*;
#(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeTernary,
  input  logic              typeBounce,
  input  logic [1:0]        ptrCountSel,
  input  logic              codeValid,
  input  logic [CODE_W-1:0] codeIn,
  output ctrlStrobeT        strobe
);
  localparam int CFG_W = 4;
  localparam logic signed [CODE_W-1:0] CODE_TOP = CODE_W'(CELL_COUNT);
  localparam logic signed [CODE_W-1:0] CODE_BOT = -CODE_TOP;

  logic [CFG_W-1:0] cfgNow, cfgQ;
  logic             cfgChanged;
  logic [SLOT_W:0]  liveCount;
  logic [SLOT_W-1:0] slotQ, slotNow, slotNext;
  logic signed [CODE_W-1:0] codeS, clamped, magWide;

  assign cfgNow     = {modeTernary, typeBounce, ptrCountSel};
  assign cfgChanged = (cfgNow != cfgQ);

  always_ff @(posedge clk) begin
    if (!rstN) cfgQ <= '0;
    else       cfgQ <= cfgNow;
  end

  // number of pointers in use
  always_comb begin
    case (ptrCountSel)
      2'd0:    liveCount = (SLOT_W+1)'(1);
      2'd1:    liveCount = (SLOT_W+1)'(2);
      default: liveCount = (SLOT_W+1)'(MAX_PTRS);
    endcase
  end

  assign slotNow  = cfgChanged ? '0 : slotQ;
  assign slotNext = (({1'b0, slotNow} + 1'b1) >= liveCount) ? '0 : slotNow + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN)          slotQ <= '0;
    else if (codeValid) slotQ <= slotNext;
    else if (cfgChanged) slotQ <= '0;
  end

  // clamp to the legal level range of the selected cell kind
  assign codeS = codeIn;
  always_comb begin
    clamped = codeS;
    if (modeTernary) begin
      if (codeS > CODE_TOP)      clamped = CODE_TOP;
      else if (codeS < CODE_BOT) clamped = CODE_BOT;
    end else begin
      if (codeS < 0)             clamped = '0;
      else if (codeS > CODE_TOP) clamped = CODE_TOP;
    end
  end
  assign magWide = (clamped < 0) ? -clamped : clamped;

  assign strobe.clear  = cfgChanged;
  assign strobe.load   = codeValid;
  assign strobe.bounce = typeBounce;
  assign strobe.neg    = (clamped < 0);
  assign strobe.slot   = slotNow;
  assign strobe.mag    = magWide[MAG_W-1:0];
endmodule

// File: rtl/dwa_path.sv
module dwa_path
  import dwa_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobeT            strobe,
  output logic [CELL_COUNT-1:0] cellPos,
  output logic [CELL_COUNT-1:0] cellNeg,
  output logic                  outValid
);
  localparam logic [MAG_W:0] SPAN = (MAG_W+1)'(CELL_COUNT);

  logic [MAG_W-1:0]        ptrQ  [MAX_PTRS];
  logic                    downQ [MAX_PTRS];
  logic [MAG_W-1:0]        base;
  logic                    goDown;
  logic [CELL_COUNT-1:0]   lowMask, wrapMask, bounceMask, mask;
  logic [2*CELL_COUNT-1:0] spread;
  logic [MAG_W:0]          sumW, wrapNext;
  logic                    upFit, dnFit;
  logic [MAG_W-1:0]        lo, bounceNext, nextPtr;
  logic                    bounceDown, nextDown;

  assign base   = strobe.clear ? '0 : ptrQ[strobe.slot];
  assign goDown = strobe.clear ? 1'b0 : downQ[strobe.slot];

  assign lowMask = {CELL_COUNT{1'b1}} >> (CELL_COUNT - int'(strobe.mag));
  assign sumW    = {1'b0, base} + {1'b0, strobe.mag};

  // wrapping rotation
  assign spread   = {{CELL_COUNT{1'b0}}, lowMask} << base[IDX_W-1:0];
  assign wrapMask = spread[CELL_COUNT-1:0] | spread[2*CELL_COUNT-1:CELL_COUNT];
  assign wrapNext = (sumW >= SPAN) ? sumW - SPAN : sumW;

  // back-and-forth rotation
  assign upFit = (sumW <= SPAN);
  assign dnFit = (base >= strobe.mag);

  always_comb begin
    if (!goDown) begin
      if (upFit) begin
        lo = base; bounceNext = sumW[MAG_W-1:0]; bounceDown = 1'b0;
      end else if (dnFit) begin
        lo = base - strobe.mag; bounceNext = lo; bounceDown = 1'b1;
      end else begin
        lo = MAG_W'(CELL_COUNT) - strobe.mag; bounceNext = lo; bounceDown = 1'b1;
      end
    end else begin
      if (dnFit) begin
        lo = base - strobe.mag; bounceNext = lo; bounceDown = 1'b1;
      end else if (upFit) begin
        lo = base; bounceNext = sumW[MAG_W-1:0]; bounceDown = 1'b0;
      end else begin
        lo = '0; bounceNext = strobe.mag; bounceDown = 1'b0;
      end
    end
  end
  assign bounceMask = lowMask << lo;

  assign mask     = strobe.bounce ? bounceMask : wrapMask;
  assign nextPtr  = strobe.bounce ? bounceNext : wrapNext[MAG_W-1:0];
  assign nextDown = strobe.bounce ? bounceDown : 1'b0;

  // one register bank per pointer
  for (genvar p = 0; p < MAX_PTRS; p++) begin : gBank
    logic [MAG_W-1:0] ptrR;
    logic             downR;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        ptrR  <= '0;
        downR <= 1'b0;
      end else if (strobe.load && strobe.slot == SLOT_W'(p)) begin
        ptrR  <= nextPtr;
        downR <= nextDown;
      end else if (strobe.clear) begin
        ptrR  <= '0;
        downR <= 1'b0;
      end
    end
    assign ptrQ[p]  = ptrR;
    assign downQ[p] = downR;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cellPos  <= '0;
      cellNeg  <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= strobe.load;
      if (strobe.load) begin
        cellPos <= strobe.neg ? '0 : mask;
        cellNeg <= strobe.neg ? mask : '0;
      end
    end
  end
endmodule

// File: rtl/dwa_sel.sv
module dwa_sel
  import dwa_pkg::*;
#(
  parameter int CODE_W = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  modeTernary,
  input  logic                  typeBounce,
  input  logic [1:0]            ptrCountSel,
  input  logic                  codeValid,
  input  logic [CODE_W-1:0]     codeIn,
  output logic [CELL_COUNT-1:0] cellPos,
  output logic [CELL_COUNT-1:0] cellNeg,
  output logic                  outValid
);
  ctrlStrobeT strobe;

  dwa_ctrl #(.CODE_W(CODE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .modeTernary(modeTernary), .typeBounce(typeBounce),
    .ptrCountSel(ptrCountSel), .codeValid(codeValid), .codeIn(codeIn), .strobe(strobe)
  );

  dwa_path uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cellPos(cellPos), .cellNeg(cellNeg), .outValid(outValid)
  );
endmodule

// File: rtl/dwa_sel_chk.sv
module dwa_sel_chk
  import dwa_pkg::*;
#(
  parameter int CODE_W = 5
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  modeTernary,
  input logic                  codeValid,
  input logic [CODE_W-1:0]     codeIn,
  input logic [CELL_COUNT-1:0] cellPos,
  input logic [CELL_COUNT-1:0] cellNeg,
  input logic                  outValid
);
  localparam logic signed [CODE_W-1:0] CODE_TOP = CODE_W'(CELL_COUNT);

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rstN |=> (!outValid && cellPos == '0 && cellNeg == '0));

  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    codeValid |=> outValid);

  assert_hold_drives_R2: assert property (@(posedge clk) disable iff (!rstN)
    !codeValid |=> ($stable(cellPos) && $stable(cellNeg)));

  assert_no_conflict_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cellPos & cellNeg) == '0);

  assert_binary_no_neg_R4: assert property (@(posedge clk) disable iff (!rstN)
    (codeValid && !modeTernary) |=> cellNeg == '0);

  assert_clamp_top_R5: assert property (@(posedge clk) disable iff (!rstN)
    (codeValid && modeTernary && $signed(codeIn) >= CODE_TOP)
      |=> (cellPos == '1 && cellNeg == '0));

  assert_clamp_binary_R5: assert property (@(posedge clk) disable iff (!rstN)
    (codeValid && !modeTernary && $signed(codeIn) <= 0) |=> cellPos == '0);
endmodule

bind dwa_sel dwa_sel_chk #(.CODE_W(CODE_W)) uChk (
  .clk(clk), .rstN(rstN), .modeTernary(modeTernary), .codeValid(codeValid),
  .codeIn(codeIn), .cellPos(cellPos), .cellNeg(cellNeg), .outValid(outValid)
);

// File: tb/sim_dwa_sel.sv
module sim_dwa_sel;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rstN, modeTernary, typeBounce, codeValid, outValid;
  logic [1:0] ptrCountSel;
  logic [4:0] codeIn;
  logic [7:0] cellPos, cellNeg;

  dwa_sel u0 (
    .clk(clk), .rstN(rstN), .modeTernary(modeTernary), .typeBounce(typeBounce),
    .ptrCountSel(ptrCountSel), .codeValid(codeValid), .codeIn(codeIn),
    .cellPos(cellPos), .cellNeg(cellNeg), .outValid(outValid)
  );

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  // {code, expected cellPos, expected cellNeg}: ternary, wrapping, one pointer
  localparam logic [20:0] VEC [10] = '{
    {5'b00011, 8'b00000111, 8'b00000000},  // +3 from 0
    {5'b11110, 8'b00000000, 8'b00011000},  // -2 from 3
    {5'b00101, 8'b11100011, 8'b00000000},  // +5 from 5, wraps
    {5'b00000, 8'b00000000, 8'b00000000},  // 0
    {5'b01000, 8'b11111111, 8'b00000000},  // +8
    {5'b11000, 8'b00000000, 8'b11111111},  // -8
    {5'b01100, 8'b11111111, 8'b00000000},  // +12 clamps to +8
    {5'b10011, 8'b00000000, 8'b11111111},  // -13 clamps to -8
    {5'b00111, 8'b11111101, 8'b00000000},  // +7 from 2
    {5'b11111, 8'b00000000, 8'b00000010}   // -1 from 1
  };

  function automatic int pop(logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic expectDrv(string tag, logic [7:0] eP, logic [7:0] eN);
    checks++;
    if (cellPos !== eP || cellNeg !== eN) begin
      errs++;
      $display("FAIL %s pos=%b neg=%b expected pos=%b neg=%b", tag, cellPos, cellNeg, eP, eN);
    end
  endtask

  task automatic expectInt(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(logic [4:0] c);
    @(negedge clk);
    codeIn = c;
    codeValid = 1'b1;
    @(negedge clk);
    codeValid = 1'b0;
  endtask

  task automatic setCfg(logic t, logic b, logic [1:0] n);
    @(negedge clk);
    modeTernary = t;
    typeBounce = b;
    ptrCountSel = n;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; modeTernary = 1'b1; typeBounce = 1'b0; ptrCountSel = 2'd0;
    codeValid = 1'b0; codeIn = '0;
    repeat (3) @(negedge clk);
    expectDrv("R1 reset drives", 8'h00, 8'h00);
    expectInt("R1 reset valid", int'(outValid), 0);
    rstN = 1'b1;

    // R6 / R5 / R3: table walk
    for (int i = 0; i < 10; i++) begin
      send(VEC[i][20:16]);
      expectDrv($sformatf("R6 vector %0d", i), VEC[i][15:8], VEC[i][7:0]);
    end

    // R2: valid timing and hold
    send(5'b00010);
    expectInt("R2 valid after strobe", int'(outValid), 1);
    expectDrv("R2 drive", 8'b00001100, 8'h00);
    @(negedge clk);
    expectInt("R2 valid drops", int'(outValid), 0);
    expectDrv("R2 drive holds", 8'b00001100, 8'h00);

    // R9 + R4: binary mode after config change starts at cell 0
    setCfg(1'b0, 1'b0, 2'd0);
    send(5'b00011);
    expectDrv("R9 R4 restart at cell 0", 8'b00000111, 8'h00);
    send(5'b11100);
    expectDrv("R4 R5 negative binary gives none", 8'h00, 8'h00);
    send(5'b01111);
    expectDrv("R4 R5 binary clamps to 8", 8'hFF, 8'h00);

    // R8: two pointers, ternary wrapping
    setCfg(1'b1, 1'b0, 2'd1);
    send(5'd2); expectDrv("R8 N2 p0", 8'b00000011, 8'h00);
    send(5'd3); expectDrv("R8 N2 p1", 8'b00000111, 8'h00);
    send(5'd1); expectDrv("R8 N2 p0 again", 8'b00000100, 8'h00);
    send(5'd1); expectDrv("R8 N2 p1 again", 8'b00001000, 8'h00);

    // R8: four pointers
    setCfg(1'b1, 1'b0, 2'd2);
    for (int i = 0; i < 4; i++) begin
      send(5'd1);
      expectDrv($sformatf("R8 N4 pointer %0d", i), 8'b00000001, 8'h00);
    end
    send(5'd1); expectDrv("R8 N4 wraps to p0", 8'b00000010, 8'h00);

    // R9: change mid-stream
    setCfg(1'b1, 1'b0, 2'd0);
    send(5'd1); expectDrv("R9 pointer cleared", 8'b00000001, 8'h00);

    // R7: binary bouncing, one pointer
    setCfg(1'b0, 1'b1, 2'd0);
    send(5'd3); expectDrv("R7 up 0..2", 8'b00000111, 8'h00);
    send(5'd3); expectDrv("R7 up 3..5", 8'b00111000, 8'h00);
    send(5'd3); expectDrv("R7 turn down 3..5", 8'b00111000, 8'h00);
    send(5'd3); expectDrv("R7 down 0..2", 8'b00000111, 8'h00);
    send(5'd5); expectDrv("R7 turn up 0..4", 8'b00011111, 8'h00);
    send(5'd5); expectDrv("R7 turn down 0..4", 8'b00011111, 8'h00);
    send(5'd6); expectDrv("R7 turn up 0..5", 8'b00111111, 8'h00);
    send(5'd4); expectDrv("R7 turn down 2..5", 8'b00111100, 8'h00);
    send(5'd7); expectDrv("R7 neither fits 0..6", 8'b01111111, 8'h00);

    // R10 + R3: equal use over eight strobes, ternary wrapping
    setCfg(1'b1, 1'b0, 2'd0);
    begin
      int useCnt [8];
      for (int c = 0; c < 8; c++) useCnt[c] = 0;
      for (int s = 0; s < 8; s++) begin
        send(5'b11101);
        expectInt($sformatf("R3 level sample %0d", s), pop(cellPos) - pop(cellNeg), -3);
        for (int c = 0; c < 8; c++) useCnt[c] += int'(cellNeg[c]);
      end
      for (int c = 0; c < 8; c++)
        expectInt($sformatf("R10 cell %0d use count", c), useCnt[c], 3);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule